// File: doc/BRIEF.md
# Software Interrupt Status and Level Mask

This block keeps the software interrupt status word of a processor thread and the current processor interrupt level (PIL) that masks it. Software changes the status word through one register-write port that offers three views of the same storage: a plain overwrite, an OR-in view and an AND-NOT view. A fourth selector on that port loads the level. A timer compare unit can raise the system-tick match bit directly through a one-cycle pulse input.

The block drives one pending line per status bit. Each line comes from combinational logic fed by the stored bits and the stored level. The two timer-match bits, bit 0 and bit 16, share a fixed level threshold of 14. Each software level bit 1 to 15 is compared against PIL using its own index. Both stored values can be read back with no wait states. Trap delivery and arbitration against other interrupt sources are handled elsewhere.

Top module: `swint_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released, the status word reads 0, the level reads 0 and every pending line is low.
- R2: A write with `wr_sel`=0 replaces the status word with `wr_data` at the next clock edge.
- R3: A write with `wr_sel`=1 ORs `wr_data` into the status word at the next clock edge.
- R4: A write with `wr_sel`=2 clears every status bit whose `wr_data` bit is 1 at the next clock edge, and leaves the other bits unchanged.
- R5: A write with `wr_sel`=3 loads `wr_data[3:0]` into the level at the next clock edge and leaves the status word unchanged. `rd_data` shows the status word when `rd_sel`=0 and the zero-extended level when `rd_sel`=1, in the same cycle.
- R6: For n from 1 to 15, `pend[n]` is high exactly when status bit n is 1 and n is strictly greater than the level.
- R7: `pend[0]` and `pend[16]` are each high exactly when their status bit is 1 and the level is below 14.
- R8: A `tm_hit` pulse sets status bit 16 at the next clock edge. If a write in the same cycle would clear or overwrite that bit, the pulse takes priority.
- R9: When `wr_en` and `tm_hit` are both low, neither the status word nor the level changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronized inside the block |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 overwrite, 1 OR-in, 2 AND-NOT, 3 level |
| wr_data | input | 17 | Write value |
| tm_hit | input | 1 | System-tick compare match pulse |
| rd_sel | input | 1 | Read target: 0 status word, 1 level |
| rd_data | output | 17 | Read value, combinational |
| pend | output | 17 | Per-bit pending soft interrupt lines |

## Verification
Every write and every `tm_hit` pulse is registered exactly once, so the status word, the level and all pending lines take their new values at the first rising edge after the stimulus. The bench drives its inputs on the falling edge and compares the results on the following falling edge, which is one register stage later. `rd_data` has no register in its path, so it is checked a short delay after `rd_sel` changes, with no clock edge in between. The assertion of reset is asynchronous and is checked before any clock edge occurs. After reset is released, the bench waits out the synchronizer before it applies the first write.

// File: rtl/swint_pkg.sv
package swint_pkg;
  localparam int STAT_W   = 17;
  localparam int LVL_W    = 4;
  localparam int TM_LEVEL = 14;
  localparam int HI_BIT   = STAT_W - 1;

  typedef enum logic [1:0] {
    WR_DIRECT = 2'd0,
    WR_SET    = 2'd1,
    WR_CLEAR  = 2'd2,
    WR_LEVEL  = 2'd3
  } wr_op_e;
endpackage

// File: rtl/swint_rst_sync.sv
module swint_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/swint_next.sv
module swint_next
  import swint_pkg::*;
#(
  parameter int SW = STAT_W,
  parameter int LW = LVL_W,
  parameter int HB = HI_BIT
) (
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [SW-1:0] wr_data,
  input  logic          tm_hit,
  input  logic [SW-1:0] status_q,
  output logic [SW-1:0] status_d,
  output logic          status_en,
  output logic [LW-1:0] pil_d,
  output logic          pil_en
);
  logic [SW-1:0] sw_val;
  logic [SW-1:0] hw_set;
  logic          sw_hit;

  always_comb begin
    sw_val = status_q;
    sw_hit = 1'b0;
    if (wr_en) begin
      unique case (wr_op_e'(wr_sel))
        WR_DIRECT: begin sw_val = wr_data;             sw_hit = 1'b1; end
        WR_SET:    begin sw_val = status_q | wr_data;  sw_hit = 1'b1; end
        WR_CLEAR:  begin sw_val = status_q & ~wr_data; sw_hit = 1'b1; end
        default:   begin sw_val = status_q;            sw_hit = 1'b0; end
      endcase
    end
  end

  always_comb begin
    hw_set     = '0;
    hw_set[HB] = tm_hit;
  end

  // The hardware set is applied after the software value, so it wins.
  assign status_d  = sw_val | hw_set;
  assign status_en = sw_hit | tm_hit;
  assign pil_d     = wr_data[LW-1:0];
  assign pil_en    = wr_en && (wr_op_e'(wr_sel) == WR_LEVEL);
endmodule

// File: rtl/swint_mask.sv
module swint_mask
  import swint_pkg::*;
#(
  parameter int SW  = STAT_W,
  parameter int LW  = LVL_W,
  parameter int THR = TM_LEVEL
) (
  input  logic [SW-1:0] status_q,
  input  logic [LW-1:0] pil_q,
  output logic [SW-1:0] pend
);
  localparam int HB = SW - 1;
  localparam logic [LW:0] THR_V = (LW+1)'(THR);

  logic [LW:0] lvl_ext;
  logic        tm_open;

  assign lvl_ext = {1'b0, pil_q};
  assign tm_open = lvl_ext < THR_V;

  genvar n;
  generate
    for (n = 0; n < SW; n++) begin : g_bit
      if (n == 0 || n == HB) begin : g_timer
        assign pend[n] = status_q[n] & tm_open;
      end else begin : g_level
        localparam logic [LW:0] IDX = (LW+1)'(n);
        assign pend[n] = status_q[n] & (IDX > lvl_ext);
      end
    end
  endgenerate
endmodule

// File: rtl/swint_ctrl.sv
module swint_ctrl
  import swint_pkg::*;
#(
  parameter int SW  = STAT_W,
  parameter int LW  = LVL_W,
  parameter int THR = TM_LEVEL
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [SW-1:0] wr_data,
  input  logic          tm_hit,
  input  logic          rd_sel,
  output logic [SW-1:0] rd_data,
  output logic [SW-1:0] pend
);
  localparam int HB = SW - 1;

  logic          rst_sync_n;
  logic [SW-1:0] status_q, status_d;
  logic          status_en;
  logic [LW-1:0] pil_q, pil_d;
  logic          pil_en;

  swint_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  swint_next #(.SW(SW), .LW(LW), .HB(HB)) u_next (
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .tm_hit    (tm_hit),
    .status_q  (status_q),
    .status_d  (status_d),
    .status_en (status_en),
    .pil_d     (pil_d),
    .pil_en    (pil_en)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)    status_q <= '0;
    else if (status_en) status_q <= status_d;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) pil_q <= '0;
    else if (pil_en) pil_q <= pil_d;
  end

  swint_mask #(.SW(SW), .LW(LW), .THR(THR)) u_mask (
    .status_q (status_q),
    .pil_q    (pil_q),
    .pend     (pend)
  );

  assign rd_data = rd_sel ? {{(SW-LW){1'b0}}, pil_q} : status_q;
endmodule

// File: rtl/swint_chk.sv
module swint_chk #(
  parameter int SW  = 17,
  parameter int LW  = 4,
  parameter int THR = 14
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [1:0]    wr_sel,
  input logic [SW-1:0] wr_data,
  input logic          tm_hit,
  input logic [SW-1:0] status_q,
  input logic [LW-1:0] pil_q,
  input logic [SW-1:0] pend
);
  localparam int HB = SW - 1;

  logic lvl_viol;
  always_comb begin
    lvl_viol = 1'b0;
    for (int n = 1; n < HB; n++)
      if (pend[n] && (n <= int'(pil_q))) lvl_viol = 1'b1;
  end

  // R1
  always @(posedge clk) if (!rst_n) a_r1_reset_clear: assert (status_q == '0 && pil_q == '0 && pend == '0);

  a_r3_set_or: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd1) |=> ((status_q & $past(wr_data)) == $past(wr_data)));

  a_r4_clear_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd2 && !tm_hit) |=> ((status_q & $past(wr_data)) == '0));

  a_r5_level_keeps_status: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd3 && !tm_hit) |=> $stable(status_q));

  a_r6_level_mask: assert property (@(posedge clk) disable iff (!rst_n) !lvl_viol);

  a_r7_timer_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (pend[0] || pend[HB]) |-> (int'(pil_q) < THR));

  a_r8_match_wins: assert property (@(posedge clk) disable iff (!rst_n)
    tm_hit |=> status_q[HB]);

  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !tm_hit) |=> ($stable(status_q) && $stable(pil_q)));
endmodule

bind swint_ctrl swint_chk #(.SW(SW), .LW(LW), .THR(THR)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .wr_en    (wr_en),
  .wr_sel   (wr_sel),
  .wr_data  (wr_data),
  .tm_hit   (tm_hit),
  .status_q (status_q),
  .pil_q    (pil_q),
  .pend     (pend)
);

// File: tb/swint_ctrl_test.sv
module swint_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int SW = 17;
  localparam int LW = 4;
  localparam int NV = 15;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [1:0]    wr_sel = 2'd0;
  logic [SW-1:0] wr_data = '0;
  logic          tm_hit = 1'b0;
  logic          rd_sel = 1'b0;
  logic [SW-1:0] rd_data;
  logic [SW-1:0] pend;

  int n_chk = 0;
  int n_fail = 0;

  swint_ctrl uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .tm_hit(tm_hit), .rd_sel(rd_sel), .rd_data(rd_data), .pend(pend)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Row layout: en, sel[1:0], data[16:0], hit, expected status[16:0], expected level[3:0]
  localparam logic [41:0] VEC [NV] = '{
    {1'b1, 2'd0, 17'h10001, 1'b0, 17'h10001, 4'd0},
    {1'b1, 2'd1, 17'h08002, 1'b0, 17'h18003, 4'd0},
    {1'b1, 2'd3, 17'h00005, 1'b0, 17'h18003, 4'd5},
    {1'b1, 2'd2, 17'h00001, 1'b0, 17'h18002, 4'd5},
    {1'b1, 2'd3, 17'h0000E, 1'b0, 17'h18002, 4'd14},
    {1'b1, 2'd3, 17'h0000D, 1'b0, 17'h18002, 4'd13},
    {1'b1, 2'd1, 17'h04000, 1'b0, 17'h1C002, 4'd13},
    {1'b1, 2'd3, 17'h0000F, 1'b0, 17'h1C002, 4'd15},
    {1'b1, 2'd3, 17'h00000, 1'b0, 17'h1C002, 4'd0},
    {1'b0, 2'd0, 17'h1FFFF, 1'b0, 17'h1C002, 4'd0},
    {1'b1, 2'd2, 17'h1FFFF, 1'b1, 17'h10000, 4'd0},
    {1'b1, 2'd0, 17'h00000, 1'b0, 17'h00000, 4'd0},
    {1'b0, 2'd2, 17'h00000, 1'b1, 17'h10000, 4'd0},
    {1'b1, 2'd0, 17'h0FFFF, 1'b1, 17'h1FFFF, 4'd0},
    {1'b1, 2'd3, 17'h1FFF7, 1'b0, 17'h1FFFF, 4'd7}
  };

  function automatic logic [SW-1:0] model_pend(input logic [SW-1:0] st, input logic [LW-1:0] lv);
    logic [SW-1:0] p;
    p = '0;
    for (int n = 1; n < SW-1; n++) p[n] = st[n] && (n > int'(lv));
    p[0]    = st[0]    && (int'(lv) < 14);
    p[SW-1] = st[SW-1] && (int'(lv) < 14);
    return p;
  endfunction

  task automatic check(input string req, input logic [SW-1:0] act, input logic [SW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_state(input string req, input logic [SW-1:0] st, input logic [LW-1:0] lv);
    rd_sel = 1'b0; #1;
    check({req, " status"}, rd_data, st);
    rd_sel = 1'b1; #1;
    check({req, " R5 level read"}, rd_data, {{(SW-LW){1'b0}}, lv});
    check({req, " pend R6/R7"}, pend, model_pend(st, lv));
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1;
    // R1: state under asserted reset
    check_state("R1 in reset", '0, '0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_state("R1 after release", '0, '0);

    for (int i = 0; i < NV; i++) begin
      logic [41:0] row;
      row = VEC[i];
      wr_en   = row[41];
      wr_sel  = row[40:39];
      wr_data = row[38:22];
      tm_hit  = row[21];
      @(negedge clk);
      wr_en = 1'b0; tm_hit = 1'b0; wr_data = '0;
      check_state($sformatf("R2/R3/R4/R8/R9 row %0d", i), row[20:4], row[3:0]);
    end

    // R7 boundary: timer bits at level 13 open, at level 14 closed
    wr_en = 1'b1; wr_sel = 2'd0; wr_data = 17'h10001;
    @(negedge clk);
    wr_sel = 2'd3; wr_data = 17'h0000D;
    @(negedge clk);
    wr_en = 1'b0;
    check_state("R7 level 13", 17'h10001, 4'd13);
    wr_en = 1'b1; wr_data = 17'h0000E;
    @(negedge clk);
    wr_en = 1'b0;
    check_state("R7 level 14", 17'h10001, 4'd14);

    // R9: idle cycles hold everything
    repeat (3) @(negedge clk);
    check_state("R9 idle hold", 17'h10001, 4'd14);

    // R1: asynchronous reset assertion mid-run
    rst_n = 1'b0; #1;
    check_state("R1 async assert", '0, '0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_state("R1 second release", '0, '0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule